// File: doc/BRIEF.md
# 4:2:2 YCbCr Byte Multiplexer

This block takes one full-resolution YCbCr pixel (luma plus both chroma components) per pixel slot, drops the chroma of every second pixel, and produces a 4:2:2 stream. It has two output arrangements, selected by a parameter. In byte mode there is a single component lane, clocked at twice the pixel rate, and each input pixel is held for two clocks. In dual-lane mode luma goes out on the upper lane and chroma on the lower lane at the pixel rate, with blue-difference and red-difference samples taking turns.

An active-line qualifier marks the pixels that belong to the picture. Every rising edge of the qualifier restarts the component order, so each line begins with the blue-difference sample of its first pixel. Picture codes that fall in the reserved bands at either end of the code range are pulled to the nearest legal value. All other values pass through unchanged, including luma below the nominal black level. While the qualifier is low, the block emits fixed blanking levels and holds the valid flag low. No timing-reference words are ever written into the stream.

The block suits the output side of a decoder or scaler that feeds a parallel 4:2:2 video port. Chroma filtering before the decimation is left to the pixel source.

Top module: `ycc_byte_mux`

## Requirements
- R1: In byte mode (WIDE=0), with each pixel held for two clocks, the output sequence for pixels 2k and 2k+1 of a line is Cb(2k), Y(2k), Cr(2k), Y(2k+1), repeating.
- R2: The first output of every line, meaning the clock after the qualifier rises, carries the blue-difference sample of the line's first pixel on the chroma lane. This holds wherever the previous line stopped in the sequence.
- R3: The Cb and Cr values presented with odd-indexed pixels (counted from 0 at line start) never reach the output. Odd pixels carry the Cr of the preceding even pixel.
- R4: A component code below 2^(CW-8) (01h at 8 bits, 004h at 10 bits) is output as 2^(CW-8).
- R5: A component code above 2^CW-1-2^(CW-8) (FEh at 8 bits, 3FBh at 10 bits) is output as that limit.
- R6: Every component code inside the limits, including luma below 16 (8-bit scale), is output unchanged.
- R7: While the qualifier is low, the valid flag is low and the data is a blanking level. In byte mode this is 80h·2^(CW-8) when the number of clocks since the last rising qualifier (or since reset) is even, and 10h·2^(CW-8) when it is odd. In dual-lane mode it is 10h·2^(CW-8) on the upper lane and 80h·2^(CW-8) on the lower lane.
- R8: The output lags the input by exactly one clock. The valid flag equals the qualifier of the previous clock.
- R9: In dual-lane mode (WIDE=1), out_data[2CW-1:CW] is the luma of the current pixel. out_data[CW-1:0] is the Cb of even pixels, and on odd pixels it is the Cr of the preceding even pixel.
- R10: During and directly after reset, the valid flag is low and the data is the even-phase blanking word: 80h·2^(CW-8) in byte mode, or the dual-lane blanking word in dual-lane mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output clock (twice the pixel rate in byte mode) |
| rst | input | 1 | Synchronous reset, active high |
| pix_act | input | 1 | Active-line qualifier |
| pix_y | input | CW | Luma of the current pixel |
| pix_cb | input | CW | Blue-difference chroma of the current pixel |
| pix_cr | input | CW | Red-difference chroma of the current pixel |
| out_vld | output | 1 | High while out_data carries picture data |
| out_data | output | OW (CW or 2·CW) | Multiplexed component word |

## Verification
The bench builds two instances side by side. The first uses 8-bit components in byte mode and covers the four-slot component order, the line restart after a line with an odd pixel count, and the 01h/FEh limits. The second uses 10-bit components in dual-lane mode and covers the 004h/3FBh limits, the wider blanking levels and the alternating chroma lane. Both instances share one clock. Because of this, the blanking-phase parity of the byte-mode instance keeps running while the other instance is busy, and it is checked throughout.

// File: rtl/ycc_mux_pkg.sv
package ycc_mux_pkg;

  // Width of each reserved band at either end of the code range.
  function automatic int band_w(int cw);
    return 1 << (cw - 8);
  endfunction

  function automatic int code_lo(int cw);
    return band_w(cw);
  endfunction

  function automatic int code_hi(int cw);
    return (1 << cw) - 1 - band_w(cw);
  endfunction

  function automatic int luma_blank(int cw);
    return 16 << (cw - 8);
  endfunction

  function automatic int chroma_blank(int cw);
    return 128 << (cw - 8);
  endfunction

endpackage

// File: rtl/ycc_phase.sv
module ycc_phase #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act,
  output logic          act_rise,
  output logic [PW-1:0] ph_now
);
  logic          act_q;
  logic [PW-1:0] ph_q;

  assign act_rise = act & ~act_q;
  assign ph_now   = act_rise ? '0 : ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      ph_q  <= '0;
    end else begin
      act_q <= act;
      ph_q  <= PW'(ph_now + 1'b1);
    end
  end
endmodule

// File: rtl/ycc_clamp.sv
module ycc_clamp #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] din,
  output logic [CW-1:0] dout
);
  import ycc_mux_pkg::*;
  localparam logic [CW-1:0] LO = CW'(code_lo(CW));
  localparam logic [CW-1:0] HI = CW'(code_hi(CW));

  always_comb begin
    if (din < LO)      dout = LO;
    else if (din > HI) dout = HI;
    else               dout = din;
  end
endmodule

// File: rtl/ycc_lane_sel.sv
module ycc_lane_sel #(
  parameter int CW   = 8,
  parameter int WIDE = 0,
  localparam int OW  = (WIDE != 0) ? 2 * CW : CW,
  localparam int PW  = (WIDE != 0) ? 1 : 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act,
  input  logic [PW-1:0] ph_now,
  input  logic [CW-1:0] y_c,
  input  logic [CW-1:0] cb_c,
  input  logic [CW-1:0] cr_c,
  output logic [OW-1:0] word_nxt
);
  import ycc_mux_pkg::*;
  localparam logic [CW-1:0] YB = CW'(luma_blank(CW));
  localparam logic [CW-1:0] CB = CW'(chroma_blank(CW));

  logic [CW-1:0] cr_hold;
  logic          even_pix;
  logic [CW-1:0] chroma;

  // The top phase bit is low for the even pixel of a pair.
  assign even_pix = ~ph_now[PW-1];
  assign chroma   = even_pix ? cb_c : cr_hold;

  always_ff @(posedge clk) begin
    if (rst)                  cr_hold <= '0;
    else if (act && even_pix) cr_hold <= cr_c;
  end

  generate
    if (WIDE != 0) begin : g_dual
      always_comb word_nxt = act ? {y_c, chroma} : {YB, CB};
    end else begin : g_byte
      logic luma_slot;
      assign luma_slot = ph_now[0];
      always_comb begin
        if (act) word_nxt = luma_slot ? y_c : chroma;
        else     word_nxt = luma_slot ? YB : CB;
      end
    end
  endgenerate
endmodule

// File: rtl/ycc_byte_mux.sv
module ycc_byte_mux #(
  parameter int CW   = 8,
  parameter int WIDE = 0,
  localparam int OW  = (WIDE != 0) ? 2 * CW : CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_act,
  input  logic [CW-1:0] pix_y,
  input  logic [CW-1:0] pix_cb,
  input  logic [CW-1:0] pix_cr,
  output logic          out_vld,
  output logic [OW-1:0] out_data
);
  import ycc_mux_pkg::*;
  localparam int PW = (WIDE != 0) ? 1 : 2;
  localparam logic [CW-1:0] YB = CW'(luma_blank(CW));
  localparam logic [CW-1:0] CB = CW'(chroma_blank(CW));
  localparam logic [OW-1:0] RST_WORD = (WIDE != 0) ? OW'({YB, CB}) : OW'(CB);

  logic          act_rise;
  logic [PW-1:0] ph_now;
  logic [CW-1:0] comp_raw [3];
  logic [CW-1:0] comp_lim [3];
  logic [OW-1:0] word_nxt;

  ycc_phase #(.PW(PW)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .act      (pix_act),
    .act_rise (act_rise),
    .ph_now   (ph_now)
  );

  assign comp_raw[0] = pix_y;
  assign comp_raw[1] = pix_cb;
  assign comp_raw[2] = pix_cr;

  generate
    for (genvar k = 0; k < 3; k++) begin : g_lim
      ycc_clamp #(.CW(CW)) u_clamp (
        .din  (comp_raw[k]),
        .dout (comp_lim[k])
      );
    end
  endgenerate

  ycc_lane_sel #(.CW(CW), .WIDE(WIDE)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .act      (pix_act),
    .ph_now   (ph_now),
    .y_c      (comp_lim[0]),
    .cb_c     (comp_lim[1]),
    .cr_c     (comp_lim[2]),
    .word_nxt (word_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= RST_WORD;
    end else begin
      out_vld  <= pix_act;
      out_data <= word_nxt;
    end
  end
endmodule

// File: rtl/ycc_byte_mux_chk.sv
module ycc_byte_mux_chk #(
  parameter int CW   = 8,
  parameter int WIDE = 0,
  localparam int OW  = (WIDE != 0) ? 2 * CW : CW,
  localparam int PW  = (WIDE != 0) ? 1 : 2
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_act,
  input logic [CW-1:0] pix_cb,
  input logic          act_rise,
  input logic [PW-1:0] ph_now,
  input logic          out_vld,
  input logic [OW-1:0] out_data
);
  import ycc_mux_pkg::*;
  localparam logic [CW-1:0] LO = CW'(code_lo(CW));
  localparam logic [CW-1:0] HI = CW'(code_hi(CW));
  localparam logic [CW-1:0] YB = CW'(luma_blank(CW));
  localparam logic [CW-1:0] CB = CW'(chroma_blank(CW));

  logic [CW-1:0] cb_lim;
  logic          blank_ok;
  logic          range_ok;

  always_comb cb_lim = (pix_cb < LO) ? LO : ((pix_cb > HI) ? HI : pix_cb);

  generate
    if (WIDE != 0) begin : g_dual
      assign blank_ok = (out_data == OW'({YB, CB}));
      assign range_ok = (out_data[CW-1:0] >= LO) && (out_data[CW-1:0] <= HI) &&
                        (out_data[OW-1:CW] >= LO) && (out_data[OW-1:CW] <= HI);
    end else begin : g_byte
      assign blank_ok = (out_data == OW'(CB)) || (out_data == OW'(YB));
      assign range_ok = (out_data >= OW'(LO)) && (out_data <= OW'(HI));
    end
  endgenerate

  // R8
  act_to_vld_chk: assert property (@(posedge clk) disable iff (rst)
    pix_act |=> out_vld);

  // R8
  idle_to_novld_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_act |=> !out_vld);

  // R7
  blank_code_chk: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> blank_ok);

  // R4 R5
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> range_ok);

  // R2
  line_start_cb_chk: assert property (@(posedge clk) disable iff (rst)
    act_rise |=> out_data[CW-1:0] == $past(cb_lim));

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_act && !act_rise) |-> ph_now == PW'($past(ph_now) + 1'b1));
endmodule

bind ycc_byte_mux ycc_byte_mux_chk #(.CW(CW), .WIDE(WIDE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pix_act  (pix_act),
  .pix_cb   (pix_cb),
  .act_rise (act_rise),
  .ph_now   (ph_now),
  .out_vld  (out_vld),
  .out_data (out_data)
);

// File: tb/sim_ycc_byte_mux.sv
module sim_ycc_byte_mux;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst;
  logic       a0, v0;
  logic [7:0] y0, cb0, cr0, d0;
  logic       a1, v1;
  logic [9:0] y1, cb1, cr1;
  logic [19:0] d1;

  ycc_byte_mux #(.CW(8), .WIDE(0)) u0 (
    .clk(clk), .rst(rst), .pix_act(a0), .pix_y(y0), .pix_cb(cb0), .pix_cr(cr0),
    .out_vld(v0), .out_data(d0));

  ycc_byte_mux #(.CW(10), .WIDE(1)) u1 (
    .clk(clk), .rst(rst), .pix_act(a1), .pix_y(y1), .pix_cb(cb1), .pix_cr(cr1),
    .out_vld(v1), .out_data(d1));

  localparam logic [19:0] BLANK1 = {10'h040, 10'h200};

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int ph0    = 0;
  int py [16];
  int pcb[16];
  int pcr[16];

  logic [7:0]  e0d[$];
  bit          e0v[$];
  string       e0t[$];
  logic [19:0] e1d[$];
  bit          e1v[$];
  string       e1t[$];

  function automatic int lim8(int v);
    if (v < 1) return 1;
    if (v > 254) return 254;
    return v;
  endfunction

  function automatic int lim10(int v);
    if (v < 4) return 4;
    if (v > 1019) return 1019;
    return v;
  endfunction

  function automatic string tg(int raw, int expv, string dflt);
    if (raw < expv) return "R4";
    if (raw > expv) return "R5";
    if (raw < 16)   return "R6";
    return dflt;
  endfunction

  function automatic logic [7:0] blank0();
    return (ph0 % 2 == 1) ? 8'h10 : 8'h80;
  endfunction

  task automatic setpix(input int i, input int y, input int cb, input int cr);
    py[i] = y; pcb[i] = cb; pcr[i] = cr;
  endtask

  // Driver: queue the outputs expected after the next rising edge, then advance.
  task automatic tick(input logic [7:0] x0, input bit xv0, input string t0,
                      input logic [19:0] x1, input bit xv1, input string t1);
    e0d.push_back(x0); e0v.push_back(xv0); e0t.push_back(t0);
    e1d.push_back(x1); e1v.push_back(xv1); e1t.push_back(t1);
    @(negedge clk);
    ph0++;
  endtask

  task automatic idle(input int n);
    a0 = 1'b0; a1 = 1'b0;
    for (int k = 0; k < n; k++) tick(blank0(), 1'b0, "R7", BLANK1, 1'b0, "R7");
  endtask

  // Byte-mode line on u0: two clocks per pixel (R1, R2, R3).
  task automatic line0(input int n);
    for (int i = 0; i < n; i++) begin
      int c, cexp;
      string ct;
      a0 = 1'b1; y0 = 8'(py[i]); cb0 = 8'(pcb[i]); cr0 = 8'(pcr[i]);
      if (i == 0) ph0 = 0;
      if (i % 2 == 0) c = pcb[i]; else c = pcr[i-1];
      cexp = lim8(c);
      if (i == 0)          ct = "R2";
      else if (i % 2 == 1) ct = tg(c, cexp, "R3");
      else                 ct = tg(c, cexp, "R1");
      tick(8'(cexp), 1'b1, ct, BLANK1, 1'b0, "R7");
      tick(8'(lim8(py[i])), 1'b1, tg(py[i], lim8(py[i]), "R1"), BLANK1, 1'b0, "R7");
    end
  endtask

  // Dual-lane line on u1: one clock per pixel (R9).
  task automatic line1(input int n);
    for (int i = 0; i < n; i++) begin
      int c, cexp;
      string t;
      a1 = 1'b1; y1 = 10'(py[i]); cb1 = 10'(pcb[i]); cr1 = 10'(pcr[i]);
      if (i % 2 == 0) c = pcb[i]; else c = pcr[i-1];
      cexp = lim10(c);
      t = tg(py[i], lim10(py[i]), tg(c, cexp, (i == 0) ? "R2" : "R9"));
      tick(blank0(), 1'b0, "R7", {10'(lim10(py[i])), 10'(cexp)}, 1'b1, t);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Monitor: compare each queued expectation just after the edge it belongs to.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (e0d.size() > 0) begin
        logic [7:0] x; bit xv; string t;
        x = e0d.pop_front(); xv = e0v.pop_front(); t = e0t.pop_front();
        checks++;
        if (v0 !== xv || d0 !== x) begin
          fails++;
          $display("FAIL %s u0 got data=%h vld=%b expected data=%h vld=%b",
                   (v0 !== xv) ? "R8" : t, d0, v0, x, xv);
        end
      end
      if (e1d.size() > 0) begin
        logic [19:0] x; bit xv; string t;
        x = e1d.pop_front(); xv = e1v.pop_front(); t = e1t.pop_front();
        checks++;
        if (v1 !== xv || d1 !== x) begin
          fails++;
          $display("FAIL %s u1 got data=%h vld=%b expected data=%h vld=%b",
                   (v1 !== xv) ? "R8" : t, d1, v1, x, xv);
        end
      end
    end
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL R8 watchdog got still-running expected finished");
    summary();
  end

  initial begin
    rst = 1'b1; a0 = 1'b0; a1 = 1'b0;
    y0 = '0; cb0 = '0; cr0 = '0; y1 = '0; cb1 = '0; cr1 = '0;
    repeat (3) @(negedge clk);
    // R10: reset state of both arrangements
    checks += 2;
    if (v0 !== 1'b0 || d0 !== 8'h80) begin
      fails++;
      $display("FAIL R10 u0 got data=%h vld=%b expected data=80 vld=0", d0, v0);
    end
    if (v1 !== 1'b0 || d1 !== BLANK1) begin
      fails++;
      $display("FAIL R10 u1 got data=%h vld=%b expected data=%h vld=0", d1, v1, BLANK1);
    end
    rst = 1'b0;
    ph0 = 0;
    idle(3);

    // R1 R3: plain 8-pixel line, odd-pixel chroma differs from the pair's
    for (int i = 0; i < 8; i++) setpix(i, 40 + 3 * i, 100 + 5 * i, 150 + 7 * i);
    line0(8);
    idle(4);

    // R2: three-pixel line stops mid-pair; one blank clock then restart on Cb
    for (int i = 0; i < 8; i++) setpix(i, 60 + i, 90 + 2 * i, 170 + 3 * i);
    line0(3);
    idle(1);
    line0(4);
    idle(3);

    // R4 R5 R6: reserved codes and sub-black luma in byte mode
    setpix(0, 0, 0, 255);
    setpix(1, 5, 33, 77);
    setpix(2, 255, 255, 0);
    setpix(3, 1, 128, 128);
    setpix(4, 254, 1, 254);
    setpix(5, 15, 2, 3);
    line0(6);
    idle(5);

    // R9: dual-lane lines, including an odd-length line and a restart
    for (int i = 0; i < 8; i++) setpix(i, 100 + 11 * i, 300 + 13 * i, 600 + 17 * i);
    line1(6);
    idle(2);
    line1(3);
    idle(2);
    // R4 R5 R6 at 10 bits
    setpix(0, 0, 2, 1023);
    setpix(1, 40, 500, 501);
    setpix(2, 1020, 1023, 3);
    setpix(3, 10, 4, 1019);
    line1(4);
    idle(3);

    @(posedge clk);
    #2;
    summary();
  end
endmodule